// File: doc/BRIEF.md
# Mixed-Radix Base Extension Unit

This block takes a value held as residues in one set of pairwise coprime moduli (the source basis) and produces the residues of the same value in a second set (the target basis). It works in two phases. First it peels the source residues into mixed-radix digits, one modulus at a time. Each step must see the result of the step before it. It then rebuilds every target residue as a weighted sum of those digits. Both phases share one modular multiply-accumulate unit, so the block performs exactly one modular operation per clock.

The moduli, the pairwise inverse table and the digit-weight table are loaded through a plain configuration port while the block is idle. A job is handed in on a valid/ready input. `in_ready` is high only while the block is idle, so a source that holds `in_valid` is stalled until the current job has finished. The result has no back-pressure. `done` pulses once, and `out_res` holds its value until the next job is accepted.

Top module: `bx_base_extend`

## Requirements
- R1: `in_ready` is high exactly when the block is idle. A job is accepted on a clock edge where `in_valid` and `in_ready` are both high. While a job is running, `in_valid` and `in_res` have no effect.
- R2: For a source value x < product of the source moduli, with residue k in bits [k*RES_W +: RES_W] of `in_res`, output residue k (same bit field of `out_res`) equals x mod target modulus k.
- R3: When a digit being subtracted exceeds the residue it is subtracted from, the difference wraps modulo that residue's modulus and the result is still exact.
- R4: The weight of digit 0 is the constant 1. Whatever is written to weight-table column 0 has no effect.
- R5: `done` rises exactly N(N-1)/2 + N² clock edges after the accepting edge.
- R6: `done` is high for exactly one cycle per job.
- R7: After `done`, `out_res` keeps its value until the next job is accepted.
- R8: Configuration writes issued while a job is running are dropped.
- R9: Configuration encoding, with `cfg_tbl` selecting the table:
  - 0: source modulus, indexed by `cfg_col`.
  - 1: target modulus, indexed by `cfg_row`.
  - 2: inverse of source modulus `cfg_row` modulo source modulus `cfg_col`.
  - 3: weight, equal to the product of source moduli 0..`cfg_col`-1 reduced by target modulus `cfg_row`.
- R10: After reset, `in_ready` = 1, `done` = 0 and `out_res` = 0.
- R11: Inverse-table entries with column ≤ row are never used. Whatever they hold has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Source residue vector is offered |
| in_ready | output | 1 | Block is idle and will accept a job |
| in_res | input | N_MOD*RES_W | Source residues, residue k at [k*RES_W +: RES_W] |
| done | output | 1 | One-cycle pulse when the target residues are final |
| out_res | output | N_MOD*RES_W | Target residues, residue k at [k*RES_W +: RES_W] |
| cfg_we | input | 1 | Configuration write strobe, honoured only while idle |
| cfg_tbl | input | 2 | Table select (see R9) |
| cfg_row | input | IDX_W | Row index |
| cfg_col | input | IDX_W | Column index |
| cfg_data | input | RES_W | Value to write |

## Verification
The only result is the target vector, and it is final when `done` rises, N(N-1)/2 + N² edges after the accepting edge. For the default N = 4 that is 22 edges. The bench counts rising edges from the accepting edge and samples `done` and `out_res` on the falling edge that follows each of them. It checks that the count equals that latency and that `done` has fallen at the next falling edge. It then checks several falling edges later that `out_res` is unchanged. The dropped handshake and the dropped configuration writes are both injected in the cycle right after acceptance. Their absence of effect is confirmed through the result of that job and of the job that follows.

// File: rtl/bx_pkg.sv
package bx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CONV = 2'd1,
    PH_ACC  = 2'd2,
    PH_FIN  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    TBL_SRC_MOD = 2'd0,
    TBL_TGT_MOD = 2'd1,
    TBL_INV     = 2'd2,
    TBL_COEF    = 2'd3
  } tbl_e;

  function automatic int unsigned job_cycles(input int unsigned n);
    return (n * (n - 1)) / 2 + n * n;
  endfunction

endpackage

// File: rtl/bx_modmac.sv
module bx_modmac #(
  parameter int RES_W = 12
) (
  input  logic [RES_W-1:0] op_a,
  input  logic [RES_W-1:0] op_sub,
  input  logic [RES_W-1:0] op_mul,
  input  logic [RES_W-1:0] op_add,
  input  logic [RES_W-1:0] modulus,
  output logic [RES_W-1:0] result
);
  localparam int PW = 2 * RES_W + 1;

  logic [RES_W-1:0] a_red;
  logic [RES_W-1:0] s_red;
  logic [RES_W:0]   diff;
  logic [PW-1:0]    prod;
  logic [PW-1:0]    prod_red;

  // ((a - sub) mod m) * mul + add, all reduced by m
  always_comb begin
    a_red    = '0;
    s_red    = '0;
    diff     = '0;
    prod     = '0;
    prod_red = '0;
    result   = '0;
    if (modulus != '0) begin
      a_red = op_a % modulus;
      s_red = op_sub % modulus;
      if (a_red >= s_red)
        diff = {1'b0, a_red} - {1'b0, s_red};
      else
        diff = {1'b0, a_red} + {1'b0, modulus} - {1'b0, s_red};
      prod     = PW'(diff) * PW'(op_mul) + PW'(op_add);
      prod_red = prod % PW'(modulus);
      result   = prod_red[RES_W-1:0];
    end
  end

endmodule

// File: rtl/bx_cfg_tables.sv
module bx_cfg_tables
  import bx_pkg::*;
#(
  parameter int N_MOD = 4,
  parameter int RES_W = 12,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_tbl,
  input  logic [IDX_W-1:0] cfg_row,
  input  logic [IDX_W-1:0] cfg_col,
  input  logic [RES_W-1:0] cfg_data,
  input  logic [IDX_W-1:0] rd_row,
  input  logic [IDX_W-1:0] rd_col,
  output logic [RES_W-1:0] src_mod_q,
  output logic [RES_W-1:0] tgt_mod_q,
  output logic [RES_W-1:0] inv_q,
  output logic [RES_W-1:0] coef_q
);
  logic [N_MOD-1:0][RES_W-1:0]             src_mod_tab;
  logic [N_MOD-1:0][RES_W-1:0]             tgt_mod_tab;
  logic [N_MOD-1:0][N_MOD-1:0][RES_W-1:0]  inv_tab;
  logic [N_MOD-1:0][N_MOD-1:0][RES_W-1:0]  coef_tab;

  logic wr_ok;
  assign wr_ok = cfg_we && !busy;

  for (genvar r = 0; r < N_MOD; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_mod_tab[r] <= '0;
        tgt_mod_tab[r] <= '0;
      end else if (wr_ok) begin
        if (cfg_tbl == TBL_SRC_MOD && cfg_col == IDX_W'(r))
          src_mod_tab[r] <= cfg_data;
        if (cfg_tbl == TBL_TGT_MOD && cfg_row == IDX_W'(r))
          tgt_mod_tab[r] <= cfg_data;
      end
    end
    for (genvar c = 0; c < N_MOD; c++) begin : g_col
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          inv_tab[r][c]  <= '0;
          coef_tab[r][c] <= '0;
        end else if (wr_ok && cfg_row == IDX_W'(r) && cfg_col == IDX_W'(c)) begin
          if (cfg_tbl == TBL_INV)  inv_tab[r][c]  <= cfg_data;
          if (cfg_tbl == TBL_COEF) coef_tab[r][c] <= cfg_data;
        end
      end
    end
  end

  always_comb begin
    src_mod_q = src_mod_tab[rd_col];
    tgt_mod_q = tgt_mod_tab[rd_row];
    inv_q     = inv_tab[rd_row][rd_col];
    coef_q    = (rd_col == '0) ? RES_W'(1) : coef_tab[rd_row][rd_col];
  end

  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(inv_tab) && $stable(coef_tab) &&
              $stable(src_mod_tab) && $stable(tgt_mod_tab))); // R8

endmodule

// File: rtl/bx_seq.sv
module bx_seq
  import bx_pkg::*;
#(
  parameter int N_MOD = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  output phase_e           phase,
  output logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] idx_j,
  output logic             busy,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_MOD - 1);
  localparam bit MULTI = (N_MOD > 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      idx_i <= '0;
      idx_j <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (accept) begin
          idx_i <= '0;
          if (MULTI) begin
            phase <= PH_CONV;
            idx_j <= IDX_W'(1);
          end else begin
            phase <= PH_ACC;
            idx_j <= '0;
          end
        end
        PH_CONV: begin
          if (idx_j == LAST) begin
            if (idx_i == LAST - IDX_W'(1)) begin
              phase <= PH_ACC;
              idx_i <= '0;
              idx_j <= '0;
            end else begin
              idx_i <= idx_i + IDX_W'(1);
              idx_j <= idx_i + IDX_W'(2);
            end
          end else begin
            idx_j <= idx_j + IDX_W'(1);
          end
        end
        PH_ACC: begin
          if (idx_j == LAST) begin
            idx_j <= '0;
            if (idx_i == LAST) phase <= PH_FIN;
            else               idx_i <= idx_i + IDX_W'(1);
          end else begin
            idx_j <= idx_j + IDX_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy = (phase != PH_IDLE);
  assign done = (phase == PH_FIN);

  AST_CONV_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CONV) |-> (idx_j > idx_i)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

endmodule

// File: rtl/bx_base_extend.sv
module bx_base_extend
  import bx_pkg::*;
#(
  parameter int N_MOD = 4,
  parameter int RES_W = 12,
  localparam int IDX_W = (N_MOD > 1) ? $clog2(N_MOD) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [N_MOD*RES_W-1:0] in_res,
  output logic                   done,
  output logic [N_MOD*RES_W-1:0] out_res,
  input  logic                   cfg_we,
  input  logic [1:0]             cfg_tbl,
  input  logic [IDX_W-1:0]       cfg_row,
  input  logic [IDX_W-1:0]       cfg_col,
  input  logic [RES_W-1:0]       cfg_data
);
  localparam int unsigned JOB_LAT = job_cycles(N_MOD);
  localparam int LAT_W = $clog2(JOB_LAT + 2) + 1;

  phase_e           phase;
  logic [IDX_W-1:0] idx_i, idx_j;
  logic             busy, accept;
  logic [RES_W-1:0] src_mod_q, tgt_mod_q, inv_q, coef_q;
  logic [RES_W-1:0] mac_a, mac_sub, mac_mul, mac_add, mac_mod, mac_out;

  logic [N_MOD-1:0][RES_W-1:0] res_q;
  logic [N_MOD-1:0][RES_W-1:0] acc_q;

  assign in_ready = (phase == PH_IDLE);
  assign accept   = in_valid && in_ready;

  bx_seq #(.N_MOD(N_MOD), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .phase(phase),
    .idx_i(idx_i), .idx_j(idx_j), .busy(busy), .done(done)
  );

  bx_cfg_tables #(.N_MOD(N_MOD), .RES_W(RES_W), .IDX_W(IDX_W)) u_tables (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .cfg_we(cfg_we), .cfg_tbl(cfg_tbl), .cfg_row(cfg_row),
    .cfg_col(cfg_col), .cfg_data(cfg_data),
    .rd_row(idx_i), .rd_col(idx_j),
    .src_mod_q(src_mod_q), .tgt_mod_q(tgt_mod_q),
    .inv_q(inv_q), .coef_q(coef_q)
  );

  // operand steering for the single shared modular MAC
  always_comb begin
    mac_a = res_q[idx_j];
    if (phase == PH_CONV) begin
      mac_sub = res_q[idx_i];
      mac_mul = inv_q;
      mac_add = '0;
      mac_mod = src_mod_q;
    end else begin
      mac_sub = '0;
      mac_mul = coef_q;
      mac_add = acc_q[idx_i];
      mac_mod = tgt_mod_q;
    end
  end

  bx_modmac #(.RES_W(RES_W)) u_mac (
    .op_a(mac_a), .op_sub(mac_sub), .op_mul(mac_mul),
    .op_add(mac_add), .modulus(mac_mod), .result(mac_out)
  );

  // res_q holds source residues, turning into mixed-radix digits in place
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      acc_q <= '0;
    end else if (accept) begin
      res_q <= in_res;
      acc_q <= '0;
    end else if (phase == PH_CONV) begin
      res_q[idx_j] <= mac_out;
    end else if (phase == PH_ACC) begin
      acc_q[idx_i] <= mac_out;
    end
  end

  assign out_res = acc_q;

  logic [LAT_W-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (accept) lat_q <= '0;
    else if (busy)   lat_q <= lat_q + LAT_W'(1);
  end

  AST_JOB_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == LAT_W'(JOB_LAT))); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_FIN) || (phase == PH_IDLE && !accept)) |=> $stable(out_res)); // R7
  AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid) |=> $stable(res_q) || (phase != PH_IDLE)); // R1

endmodule

// File: tb/bx_base_extend_bench.sv
module bx_base_extend_bench;
  localparam int N = 4;
  localparam int W = 12;
  localparam int IW = 2;
  localparam int LAT = (N * (N - 1)) / 2 + N * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [N*W-1:0] in_res = '0;
  logic done;
  logic [N*W-1:0] out_res;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_tbl = '0;
  logic [IW-1:0] cfg_row = '0, cfg_col = '0;
  logic [W-1:0] cfg_data = '0;

  int nchk = 0;
  int nfail = 0;

  longint unsigned smod [N] = '{4093, 4091, 4079, 4073};
  longint unsigned tmod [N] = '{4057, 4051, 4049, 4027};
  longint unsigned prod_src;

  always #10 clk = ~clk;

  bx_base_extend #(.N_MOD(N), .RES_W(W)) u_bx_base_extend (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_res(in_res), .done(done), .out_res(out_res),
    .cfg_we(cfg_we), .cfg_tbl(cfg_tbl), .cfg_row(cfg_row),
    .cfg_col(cfg_col), .cfg_data(cfg_data)
  );

  task automatic check(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint unsigned modinv(input longint unsigned a, input longint unsigned m);
    longint r0 = longint'(m), r1 = longint'(a % m), t0 = 0, t1 = 1;
    while (r1 != 0) begin
      longint q = r0 / r1;
      longint tmp = r0 - q * r1;
      r0 = r1; r1 = tmp;
      tmp = t0 - q * t1;
      t0 = t1; t1 = tmp;
    end
    if (t0 < 0) t0 = t0 + longint'(m);
    return longint'(t0);
  endfunction

  task automatic cfg_write(input int tbl, input int row, input int col, input longint unsigned data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_tbl = 2'(tbl); cfg_row = IW'(row); cfg_col = IW'(col); cfg_data = W'(data);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_tables();
    for (int k = 0; k < N; k++) begin
      cfg_write(0, 0, k, smod[k]);
      cfg_write(1, k, 0, tmod[k]);
    end
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (j > i) cfg_write(2, i, j, modinv(smod[i] % smod[j], smod[j]));
        else       cfg_write(2, i, j, 777); // R11: unused entries hold junk
      end
    end
    for (int i = 0; i < N; i++) begin
      longint unsigned w = 1;
      for (int j = 0; j < N; j++) begin
        if (j == 0) cfg_write(3, i, 0, 999); // R4: column 0 junk
        else        cfg_write(3, i, j, w);
        w = (w * smod[j]) % tmod[i];
      end
    end
  endtask

  task automatic run_case(input longint unsigned x, input string tag, input bit poke);
    logic [N*W-1:0] vec;
    longint unsigned expv [N];
    int cnt;
    for (int k = 0; k < N; k++) begin
      vec[k*W +: W] = W'(x % smod[k]);
      expv[k] = x % tmod[k];
    end
    @(negedge clk);
    check({"R1 ready when idle ", tag}, in_ready, 1);
    in_res = vec; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (poke) begin
      in_valid = 1'b1; in_res = ~vec;
      cfg_we = 1'b1; cfg_tbl = 2'd1; cfg_row = '0; cfg_data = W'(7);
      check({"R1 not ready while busy ", tag}, in_ready, 0);
    end
    cnt = 0;
    while (cnt < 1000) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (poke && cnt == 1) begin
        in_valid = 1'b0; cfg_we = 1'b0;
      end
      if (done) break;
    end
    check({"R5 latency ", tag}, cnt, LAT);
    for (int k = 0; k < N; k++)
      check({"R2/R9 residue ", tag}, longint'(out_res[k*W +: W]), longint'(expv[k]));
    @(posedge clk);
    @(negedge clk);
    check({"R6 done single cycle ", tag}, done, 0);
    repeat (3) @(negedge clk);
    for (int k = 0; k < N; k++)
      check({"R7 output held ", tag}, longint'(out_res[k*W +: W]), longint'(expv[k]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    prod_src = 1;
    for (int k = 0; k < N; k++) prod_src = prod_src * smod[k];
    repeat (3) @(negedge clk);
    check("R10 ready after reset", in_ready, 1);
    check("R10 done after reset", done, 0);
    check("R10 out after reset", longint'(out_res), 0);
    rst_n = 1'b1;
    load_tables();

    run_case(0, "zero", 1'b0);
    run_case(1, "one", 1'b0);
    run_case(4092, "R3 wrap", 1'b0);
    run_case(smod[0], "first modulus", 1'b0);
    run_case(prod_src - 1, "max", 1'b0);
    run_case(({$urandom, $urandom}) % prod_src, "R8 busy poke", 1'b1);
    run_case(123456789, "R8 after poke", 1'b0);
    for (int n = 0; n < 20; n++)
      run_case(({$urandom, $urandom}) % prod_src, "R4 R11 random", 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule